// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 18-bit data ports, A and B, and moves data through registers in both directions. Data going from A to B is captured by a single register on its own clock. Data going from B to A is captured both by a single register and by a four-stage pipeline. A select input picks which of the two drives port A. The first two pipeline stages and the single register run on one B-to-A clock, and the last two stages run on a second B-to-A clock.

Each direction has an active-low clock enable, which stalls its registers, and an active-low output enable. Tri-state pads are modelled as a data output plus a drive-enable output per port. Each input port also carries a "driven" flag. When that flag is low, a keeper supplies the last value seen while the port was driven, so registers never capture an unknown level. An active-low asynchronous reset clears every register and keeper to zero.

Top module: `brt_xcvr`

## Requirements
- R1: While rst_ni is low, all registers and keepers are zero, with or without a clock edge, so a_o and b_o read 0.
- R2: On each rising edge of clk_ab_i with cke_ab_ni low, the A-to-B register captures the resolved A value. b_o always shows that register, so a new value appears one clk_ab_i edge after it is presented.
- R3: On a rising edge of clk_ab_i with cke_ab_ni high, the A-to-B register keeps its contents.
- R4: With sel_pipe_i low (0), a_o shows the B-to-A single register. That register captures the resolved B value on each rising edge of clk_ba1_i with cke_ba_ni low.
- R5: With sel_pipe_i high (1), a_o shows pipeline stage 4. Stages 1 and 2 advance on rising edges of clk_ba1_i, and stages 3 and 4 advance on rising edges of clk_ba2_i. With both clocks pulsing together, data reaches a_o four edges after it is presented. A stopped clk_ba2_i freezes stages 3 and 4.
- R6: With cke_ba_ni high, the single register and every pipeline stage keep their contents on edges of either B-to-A clock. The path stalls and inserts no bubbles.
- R7: The single register and the pipeline load in parallel whatever the value of sel_pipe_i. Changing sel_pipe_i only changes which of them drives a_o and flushes nothing.
- R8: a_oe_o is 1 exactly when oe_ba_ni is 0, and b_oe_o is 1 exactly when oe_ab_ni is 0. The output enables have no effect on a_o, b_o or any stored data.
- R9: With a_drv_i low, the resolved A value is the last a_i sampled at a rising clk_ab_i edge while a_drv_i was high, or zero if there was none since reset. B works the same way with b_drv_i and clk_ba1_i. Keepers update on every such edge regardless of the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | A-to-B capture clock |
| clk_ba1_i | input | 1 | B-to-A clock for single register and stages 1-2 |
| clk_ba2_i | input | 1 | B-to-A clock for stages 3-4 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ab_ni | input | 1 | A-to-B clock enable, active low |
| cke_ba_ni | input | 1 | B-to-A clock enable, active low |
| oe_ab_ni | input | 1 | B-side output enable, active low |
| oe_ba_ni | input | 1 | A-side output enable, active low |
| sel_pipe_i | input | 1 | 1 = pipelined B-to-A path, 0 = single register |
| a_i | input | 18 | Value seen on port A |
| a_drv_i | input | 1 | Port A is being driven externally |
| b_i | input | 18 | Value seen on port B |
| b_drv_i | input | 1 | Port B is being driven externally |
| a_o | output | 18 | Data driven onto port A |
| a_oe_o | output | 1 | Port A drive enable |
| b_o | output | 18 | Data driven onto port B |
| b_oe_o | output | 1 | Port B drive enable |

## Verification
The bench stops clk_ba2_i while clk_ba1_i keeps running. A design that put all four stages on one clock would keep advancing a_o in that window, and the bench would see it. The bench stalls the B-to-A path and then flips the select both ways. A design that flushed data, or that loaded only the selected path, would show stale or zero data after the flip. The bench also releases a port right after a clock-enabled-off period, which exposes a keeper that only updates on enabled edges. A free-running phase with random gated clocks, enables and select is then compared on every cycle against a behavioural model.

// File: rtl/brt_pkg.sv
package brt_pkg;
  parameter int unsigned BRT_DW     = 18;
  parameter int unsigned BRT_STAGES = 4;
  parameter int unsigned BRT_SPLIT  = 2;

  typedef enum logic {
    PATH_SINGLE = 1'b0,
    PATH_PIPE   = 1'b1
  } ba_path_e;
endpackage

// File: rtl/brt_keeper.sv
module brt_keeper #(
  parameter int unsigned DW = brt_pkg::BRT_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drv_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    keep_q <= '0;
    else if (drv_i) keep_q <= d_i;
  end

  assign res_o = drv_i ? d_i : keep_q;
endmodule

// File: rtl/brt_reg.sv
module brt_reg #(
  parameter int unsigned DW = brt_pkg::BRT_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!en_ni) q_o <= d_i;
  end
endmodule

// File: rtl/brt_ba_path.sv
module brt_ba_path #(
  parameter int unsigned DW     = brt_pkg::BRT_DW,
  parameter int unsigned STAGES = brt_pkg::BRT_STAGES,
  parameter int unsigned SPLIT  = brt_pkg::BRT_SPLIT
) (
  input  logic          clk1_i,
  input  logic          clk2_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  brt_pkg::ba_path_e sel_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [DW-1:0] single_q;
  logic [DW-1:0] st_q [STAGES];

  brt_reg #(.DW(DW)) u_single (
    .clk_i(clk1_i), .rst_ni(rst_ni), .en_ni(cke_ni), .d_i(d_i), .q_o(single_q)
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [DW-1:0] st_d;
    if (g == 0) begin : g_head
      assign st_d = d_i;
    end else begin : g_link
      assign st_d = st_q[g-1];
    end
    // early stages on the first clock, late stages on the second
    if (g < SPLIT) begin : g_clk1
      brt_reg #(.DW(DW)) u_st (
        .clk_i(clk1_i), .rst_ni(rst_ni), .en_ni(cke_ni), .d_i(st_d), .q_o(st_q[g])
      );
    end else begin : g_clk2
      brt_reg #(.DW(DW)) u_st (
        .clk_i(clk2_i), .rst_ni(rst_ni), .en_ni(cke_ni), .d_i(st_d), .q_o(st_q[g])
      );
    end
  end

  assign q_o = (sel_i == brt_pkg::PATH_PIPE) ? st_q[LAST] : single_q;
endmodule

// File: rtl/brt_xcvr.sv
module brt_xcvr #(
  parameter int unsigned DW     = brt_pkg::BRT_DW,
  parameter int unsigned STAGES = brt_pkg::BRT_STAGES,
  parameter int unsigned SPLIT  = brt_pkg::BRT_SPLIT
) (
  input  logic          clk_ab_i,
  input  logic          clk_ba1_i,
  input  logic          clk_ba2_i,
  input  logic          rst_ni,
  input  logic          cke_ab_ni,
  input  logic          cke_ba_ni,
  input  logic          oe_ab_ni,
  input  logic          oe_ba_ni,
  input  logic          sel_pipe_i,
  input  logic [DW-1:0] a_i,
  input  logic          a_drv_i,
  input  logic [DW-1:0] b_i,
  input  logic          b_drv_i,
  output logic [DW-1:0] a_o,
  output logic          a_oe_o,
  output logic [DW-1:0] b_o,
  output logic          b_oe_o
);
  logic [DW-1:0] a_res, b_res;
  brt_pkg::ba_path_e sel;

  assign sel = brt_pkg::ba_path_e'(sel_pipe_i);

  brt_keeper #(.DW(DW)) u_keep_a (
    .clk_i(clk_ab_i), .rst_ni(rst_ni), .drv_i(a_drv_i), .d_i(a_i), .res_o(a_res)
  );

  brt_keeper #(.DW(DW)) u_keep_b (
    .clk_i(clk_ba1_i), .rst_ni(rst_ni), .drv_i(b_drv_i), .d_i(b_i), .res_o(b_res)
  );

  brt_reg #(.DW(DW)) u_ab (
    .clk_i(clk_ab_i), .rst_ni(rst_ni), .en_ni(cke_ab_ni), .d_i(a_res), .q_o(b_o)
  );

  brt_ba_path #(.DW(DW), .STAGES(STAGES), .SPLIT(SPLIT)) u_ba (
    .clk1_i(clk_ba1_i), .clk2_i(clk_ba2_i), .rst_ni(rst_ni), .cke_ni(cke_ba_ni),
    .sel_i(sel), .d_i(b_res), .q_o(a_o)
  );

  assign a_oe_o = ~oe_ba_ni;
  assign b_oe_o = ~oe_ab_ni;
endmodule

// File: rtl/brt_xcvr_chk.sv
module brt_xcvr_chk #(
  parameter int unsigned DW = brt_pkg::BRT_DW
) (
  input logic          clk_ab_i,
  input logic          clk_ba1_i,
  input logic          clk_ba2_i,
  input logic          rst_ni,
  input logic          cke_ab_ni,
  input logic          cke_ba_ni,
  input logic          sel_pipe_i,
  input logic [DW-1:0] a_i,
  input logic          a_drv_i,
  input logic [DW-1:0] b_i,
  input logic          b_drv_i,
  input logic [DW-1:0] a_o,
  input logic [DW-1:0] b_o,
  input logic [DW-1:0] single_q,
  input logic [DW-1:0] pre_last_q
);
  // R1
  always @(posedge clk_ab_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (b_o == '0 && single_q == '0);
    end
  end

  // R2
  ab_capture_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!cke_ab_ni && a_drv_i) |=> (b_o == $past(a_i)));

  // R3
  ab_hold_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    cke_ab_ni |=> $stable(b_o));

  // R4
  ba_single_chk: assert property (@(posedge clk_ba1_i) disable iff (!rst_ni)
    (!cke_ba_ni && b_drv_i) |=> (sel_pipe_i || a_o == $past(b_i)));

  // R5
  ba_tail_chk: assert property (@(posedge clk_ba2_i) disable iff (!rst_ni)
    !cke_ba_ni |=> (!sel_pipe_i || a_o == $past(pre_last_q)));

  // R6
  ba_stall_chk: assert property (@(posedge clk_ba1_i) disable iff (!rst_ni)
    cke_ba_ni |=> $stable(single_q));
endmodule

bind brt_xcvr brt_xcvr_chk #(.DW(DW)) u_chk (
  .clk_ab_i(clk_ab_i), .clk_ba1_i(clk_ba1_i), .clk_ba2_i(clk_ba2_i), .rst_ni(rst_ni),
  .cke_ab_ni(cke_ab_ni), .cke_ba_ni(cke_ba_ni), .sel_pipe_i(sel_pipe_i),
  .a_i(a_i), .a_drv_i(a_drv_i), .b_i(b_i), .b_drv_i(b_drv_i),
  .a_o(a_o), .b_o(b_o), .single_q(u_ba.single_q), .pre_last_q(u_ba.st_q[STAGES-2])
);

// File: tb/brt_xcvr_test.sv
module brt_xcvr_test;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic run_ab = 1'b1, run1 = 1'b1, run2 = 1'b1;
  logic rst_n = 1'b0;
  logic cke_ab_n = 1'b1, cke_ba_n = 1'b1, oe_ab_n = 1'b1, oe_ba_n = 1'b1, sel = 1'b0;
  logic a_drv = 1'b0, b_drv = 1'b0;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic [DW-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic clk_ab, clk1, clk2;

  assign clk_ab = clk & run_ab;
  assign clk1   = clk & run1;
  assign clk2   = clk & run2;

  always #5 clk = ~clk;

  brt_xcvr uut (
    .clk_ab_i(clk_ab), .clk_ba1_i(clk1), .clk_ba2_i(clk2), .rst_ni(rst_n),
    .cke_ab_ni(cke_ab_n), .cke_ba_ni(cke_ba_n), .oe_ab_ni(oe_ab_n), .oe_ba_ni(oe_ba_n),
    .sel_pipe_i(sel), .a_i(a_in), .a_drv_i(a_drv), .b_i(b_in), .b_drv_i(b_drv),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  // behavioural reference
  logic [DW-1:0] m_ab, m_keep_a, m_keep_b, m_single;
  logic [DW-1:0] m_pipe [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab = '0; m_keep_a = '0; m_keep_b = '0; m_single = '0;
      m_pipe = '{'0, '0, '0, '0};
    end else begin
      logic [DW-1:0] old [$];
      logic [DW-1:0] bres;
      old = m_pipe;
      if (run_ab) begin
        if (!cke_ab_n) m_ab = a_drv ? a_in : m_keep_a;
        if (a_drv) m_keep_a = a_in;
      end
      if (run1) begin
        bres = b_drv ? b_in : m_keep_b;
        if (b_drv) m_keep_b = b_in;
        if (!cke_ba_n) begin
          m_single = bres;
          m_pipe[0] = bres;
          m_pipe[1] = old[0];
        end
      end
      if (run2 && !cke_ba_n) begin
        m_pipe[2] = old[1];
        m_pipe[3] = old[2];
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(cur_req, b_out, m_ab);
    chk(cur_req, a_out, sel ? m_pipe[3] : m_single);
    chk("R8", {17'd0, a_oe}, {17'd0, ~oe_ba_n});
    chk("R8", {17'd0, b_oe}, {17'd0, ~oe_ab_n});
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_model();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_pipe = '{'0, '0, '0, '0};
    tick(); tick();
    chk("R1", b_out, '0); chk("R1", a_out, '0);
    chk("R8", {17'd0, a_oe}, '0);
    rst_n = 1'b1;

    // R2 A-to-B capture
    cur_req = "R2";
    a_drv = 1; a_in = 18'h1234A; cke_ab_n = 0; tick();
    chk("R2", b_out, 18'h1234A);
    a_in = 18'h3FFFF; tick();
    chk("R2", b_out, 18'h3FFFF);

    // R3 hold while keeper still tracks
    cur_req = "R3";
    cke_ab_n = 1; a_in = 18'h00055; tick(); tick();
    chk("R3", b_out, 18'h3FFFF);

    // R9 A-side keeper
    cur_req = "R9";
    cke_ab_n = 0; a_drv = 0; a_in = 18'h0AAAA; tick();
    chk("R9", b_out, 18'h00055);

    // R4 single path
    cur_req = "R4";
    sel = 0; cke_ba_n = 0; b_drv = 1; b_in = 18'h2468A; tick();
    chk("R4", a_out, 18'h2468A);

    // R5 pipeline, R7 parallel load
    cur_req = "R5";
    sel = 1;
    b_in = 18'h11111; tick();
    b_in = 18'h22222; tick();
    b_in = 18'h33333; tick();
    chk("R7", a_out, 18'h2468A);
    b_in = 18'h04444; tick();
    chk("R5", a_out, 18'h11111);
    run2 = 0;
    b_in = 18'h05555; tick();
    chk("R5", a_out, 18'h11111);
    b_in = 18'h06666; tick();
    chk("R5", a_out, 18'h11111);
    run2 = 1;
    b_in = 18'h07777; tick();
    chk("R5", a_out, 18'h22222);

    // R6 stall, R7 select toggle
    cur_req = "R6";
    cke_ba_n = 1; b_in = 18'h3ABCD; tick(); tick(); tick();
    chk("R6", a_out, 18'h22222);
    cur_req = "R7";
    sel = 0; tick();
    chk("R7", a_out, 18'h07777);
    sel = 1; tick();
    chk("R7", a_out, 18'h22222);

    // R9 B-side keeper
    cur_req = "R9";
    sel = 0; cke_ba_n = 0; b_drv = 0; b_in = 18'h12345; tick();
    chk("R9", a_out, 18'h3ABCD);

    // R8 output enables
    cur_req = "R8";
    cke_ab_n = 1; cke_ba_n = 1;
    oe_ab_n = 0; oe_ba_n = 1; tick();
    chk("R8", {17'd0, b_oe}, 18'd1); chk("R8", {17'd0, a_oe}, 18'd0);
    chk("R8", a_out, 18'h3ABCD);
    oe_ab_n = 1; oe_ba_n = 0; tick();
    chk("R8", {17'd0, a_oe}, 18'd1); chk("R8", b_out, 18'h00055);

    // R1 asynchronous reset mid-run
    rst_n = 0; #1;
    chk("R1", b_out, '0); chk("R1", a_out, '0);
    cur_req = "R1"; tick();
    rst_n = 1;

    // free-running mixed phase
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_ab = r[0] | r[1]; run1 = r[2] | r[3]; run2 = r[4] | r[5];
      cke_ab_n = r[6] & r[7]; cke_ba_n = r[8] & r[9];
      sel = r[10]; a_drv = r[11] | r[12]; b_drv = r[13] | r[14];
      oe_ab_n = r[15]; oe_ba_n = r[16];
      a_in = DW'($urandom); b_in = DW'($urandom);
      tick();
    end
    finish_run();
  end
endmodule